// File: doc/BRIEF.md
# Dual-Organization Mask ROM with Programmable Chip Enables

This block is a 4096-bit read-only array with no clock. A static organization input selects how it is read. When the input is high it is read as 512 bytes. When the input is low it is read as 1024 nibbles. In nibble organization the top address line chooses which interleaved half of the stored byte reaches the pins. A nibble uses either the even-indexed or the odd-indexed bit positions, and the other four pins float.

The array image and the active level of each of the two chip enables are parameters. Several devices can therefore share one data bus. Each device answers only to its own enable pattern, and a device that is not selected releases every pin to high impedance. For each bit, the block brings out a data value and an output enable. The top level turns these into the three-state bus pins.

Top module: `rom_dual_org`

## Requirements
- R1: With org_i=1, addr_i[9]=0 and the device enabled, oe_o is 8'hFF and data_o equals the stored byte at index addr_i[8:0]. Byte k occupies INIT bits [8k+7:8k].
- R2: With org_i=0, addr_i[9]=1 and the device enabled, oe_o is 8'h55, which drives bits 0, 2, 4 and 6. data_o is the stored byte at addr_i[8:0] ANDed with 8'h55.
- R3: With org_i=0, addr_i[9]=0 and the device enabled, oe_o is 8'hAA, which drives bits 1, 3, 5 and 7. data_o is the stored byte ANDed with 8'hAA.
- R4: The device is enabled only when ce1_i equals CE1_ACT and ce2_i equals CE2_ACT. In every other case oe_o is 8'h00.
- R5: With org_i=1 and addr_i[9]=1, the address is out of range, and oe_o is 8'h00 whatever the enables are.
- R6: Every bit of data_o whose oe_o bit is 0 reads 0.
- R7: Each bus_io bit carries the matching data_o bit while its oe_o bit is 1. Otherwise it is high impedance.
- R8: Outputs are a pure function of the present inputs. A change on any input shows at the outputs within the same time step, without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 10 | Bits [8:0] give the byte index. Bit 9 is the nibble-half select, or must be 0 in byte organization. |
| org_i | input | 1 | Organization: 1 = 512x8, 0 = 1024x4 |
| ce1_i | input | 1 | Chip enable 1, with its active level set by CE1_ACT |
| ce2_i | input | 1 | Chip enable 2, with its active level set by CE2_ACT |
| data_o | output | 8 | Per-bit read data, forced to 0 where not driven |
| oe_o | output | 8 | Per-bit output enable |
| bus_io | inout | 8 | Three-state data pins |

## Verification
The assertions assume that org_i is strapped and that all inputs carry known 0/1 values. They are evaluated only while no input is unknown, so the floating inputs before the first drive are never checked. The stimulus drives every input from the first cycle and sweeps all 1024 address values under both organizations and all four enable combinations, with the enable polarities mixed (one active low, one active high). The out-of-range byte-organization addresses are applied on purpose and logged as misuse, so that R5 is covered.

// File: rtl/rom_dual_org_pkg.sv
package rom_dual_org_pkg;
  typedef enum logic {
    ORG_NIBBLE = 1'b0,
    ORG_BYTE   = 1'b1
  } org_e;

  // mask of even-indexed bit positions for a given width
  function automatic logic [63:0] even_lanes(input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < w && i < 64; i += 2) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rom_array.sv
module rom_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH*DATA_W-1:0] INIT = '0
) (
  input  logic [ADDR_W-1:0] idx_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = INIT[g*DATA_W +: DATA_W];
  end

  assign word_o = mem[idx_i];
endmodule

// File: rtl/rom_enable_qual.sv
module rom_enable_qual #(
  parameter bit CE1_ACT = 1'b0,
  parameter bit CE2_ACT = 1'b0
) (
  input  logic ce1_i,
  input  logic ce2_i,
  output logic en_o
);
  assign en_o = (ce1_i == CE1_ACT) && (ce2_i == CE2_ACT);
endmodule

// File: rtl/rom_lane_steer.sv
module rom_lane_steer
  import rom_dual_org_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  org_e              org_i,
  input  logic              hi_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] oe_o
);
  localparam logic [63:0]       EVEN64 = even_lanes(DATA_W);
  localparam logic [DATA_W-1:0] EVEN_M = EVEN64[DATA_W-1:0];
  localparam logic [DATA_W-1:0] ODD_M  = ~EVEN_M;

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    localparam bit IS_EVEN = (g % 2) == 0;
    logic drive;
    // nibble mode: top line high picks even-indexed lanes
    assign drive = en_i && ((org_i == ORG_BYTE) ? !hi_i : (hi_i == IS_EVEN));
    assign oe_o[g]   = drive;
    assign data_o[g] = drive & word_i[g];
  end

  always_comb begin
    if (!$isunknown({org_i, hi_i, en_i, word_i})) begin
      if (!en_i)
        p_off_when_disabled_r4: assert (oe_o == '0);
      if (org_i == ORG_BYTE && hi_i)
        p_byte_range_off_r5: assert (oe_o == '0);
      p_lane_shape_r3: assert (oe_o == '0 || oe_o == '1 || oe_o == EVEN_M || oe_o == ODD_M);
      if (en_i && org_i == ORG_BYTE && !hi_i)
        p_byte_full_r1: assert (data_o == word_i);
      p_quiet_data_r6: assert ((data_o & ~oe_o) == '0);
    end
  end
endmodule

// File: rtl/rom_dual_org.sv
module rom_dual_org
  import rom_dual_org_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter bit CE1_ACT = 1'b0,
  parameter bit CE2_ACT = 1'b0,
  localparam int DEPTH = 1 << ADDR_W,
  parameter logic [DEPTH*DATA_W-1:0] INIT = '0
) (
  input  logic [ADDR_W:0]   addr_i,
  input  logic              org_i,
  input  logic              ce1_i,
  input  logic              ce2_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] oe_o,
  inout  wire  [DATA_W-1:0] bus_io
);
  logic [DATA_W-1:0] word;
  logic              en;
  org_e              org;

  assign org = org_e'(org_i);

  rom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT(INIT)) u_array (
    .idx_i  (addr_i[ADDR_W-1:0]),
    .word_o (word)
  );

  rom_enable_qual #(.CE1_ACT(CE1_ACT), .CE2_ACT(CE2_ACT)) u_enable (
    .ce1_i (ce1_i),
    .ce2_i (ce2_i),
    .en_o  (en)
  );

  rom_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .org_i  (org),
    .hi_i   (addr_i[ADDR_W]),
    .en_i   (en),
    .word_i (word),
    .data_o (data_o),
    .oe_o   (oe_o)
  );

  for (genvar g = 0; g < DATA_W; g++) begin : g_pin
    assign bus_io[g] = oe_o[g] ? data_o[g] : 1'bz;
  end

  always_comb begin
    if (!$isunknown({addr_i, ce1_i, ce2_i}) && (ce1_i != CE1_ACT || ce2_i != CE2_ACT))
      p_pins_released_r4: assert (oe_o == '0);
  end
endmodule

// File: tb/rom_dual_org_test.sv
module rom_dual_org_test;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam bit CE1_A  = 1'b0;
  localparam bit CE2_A  = 1'b1;

  function automatic logic [7:0] pat(input int k);
    int v;
    v = (k * 73) ^ (k >> 2) ^ 8'hC3;
    return v[7:0];
  endfunction

  function automatic logic [DEPTH*DATA_W-1:0] build_image();
    logic [DEPTH*DATA_W-1:0] img;
    for (int k = 0; k < DEPTH; k++) img[k*DATA_W +: DATA_W] = pat(k);
    return img;
  endfunction

  localparam logic [DEPTH*DATA_W-1:0] IMG = build_image();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ADDR_W:0] addr;
  logic org, ce1, ce2;
  logic [7:0] data, oe;
  wire  [7:0] bus;

  int checks = 0, fails = 0, misuse = 0;

  typedef struct { logic [7:0] d; logic [7:0] o; string tag; } exp_t;
  exp_t q[$];

  rom_dual_org #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CE1_ACT(CE1_A), .CE2_ACT(CE2_A), .INIT(IMG)) uut (
    .addr_i (addr), .org_i (org), .ce1_i (ce1), .ce2_i (ce2),
    .data_o (data), .oe_o (oe), .bus_io (bus)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h addr=%h org=%b ce=%b%b", tag, act, exp, addr, org, ce1, ce2);
    end
  endtask

  function automatic exp_t model(input int a, input bit m, input bit c1, input bit c2);
    exp_t e;
    bit hi;
    hi = a[ADDR_W];
    if (!(c1 == CE1_A && c2 == CE2_A)) begin e.o = 8'h00; e.tag = "R4"; end
    else if (m && hi) begin e.o = 8'h00; e.tag = "R5"; end
    else if (m) begin e.o = 8'hFF; e.tag = "R1"; end
    else if (hi) begin e.o = 8'h55; e.tag = "R2"; end
    else begin e.o = 8'hAA; e.tag = "R3"; end
    e.d = pat(a % DEPTH) & e.o;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    check(e.tag, oe, e.o);
    check((e.o == 8'hFF) ? e.tag : "R6", data, e.d);
    check("R7", bus & e.o, e.d);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    addr = '0; org = 1'b1; ce1 = ~CE1_A; ce2 = ~CE2_A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset", oe, 8'h00);
    rst_n = 1'b1;

    for (int a = 0; a < 2 * DEPTH; a++) begin
      for (int m = 0; m < 2; m++) begin
        for (int c = 0; c < 4; c++) begin
          @(posedge clk); #1;
          addr = a[ADDR_W:0]; org = m[0]; ce1 = c[0]; ce2 = c[1];
          if (m == 1 && a >= DEPTH && c == 2) misuse++;
          q.push_back(model(a, m[0], c[0], c[1]));
          @(negedge clk);
          compare(q.pop_front());
        end
      end
    end

    // R8: no clock edge between input change and sample
    @(negedge clk);
    addr = 10'h005; org = 1'b1; ce1 = CE1_A; ce2 = CE2_A;
    #0.5;
    check("R8 byte", data, pat(5));
    addr = 10'h205; org = 1'b0;
    #0.5;
    check("R8 nibble", data, pat(5) & 8'h55);
    ce2 = ~CE2_A;
    #0.5;
    check("R8 release", oe, 8'h00);

    $display("note: %0d out-of-range byte reads applied as misuse", misuse);
    finish_run();
  end
endmodule